// File: doc/BRIEF.md
# Out-of-Order Issue Buffer with Result Snooping

This block holds renamed micro-operations until their source operands are available, then sends them to execution. Each cycle it can take up to three micro-operations. Every source operand arrives in one of two forms: as a value that is already known, or as the tag of the operation that will produce it. Waiting sources watch a single result bus. When the tag on that bus matches a waiting source, the value on the bus is copied into the entry, so the entry ends up holding its operand values.

There are five execution ports: two integer, one load-address, one store-address and one floating-point. Each cycle, every port independently takes the oldest ready micro-operation that is steered to it. The entry that port uses is released at the next clock edge. The block has a stall output that tells the front end that fewer than three entries are free. A recovery flush empties the whole buffer.

Top module: `rs_station`

## Requirements
- R1: While reset is held and in the first cycle after it, the buffer is empty: `stall` is 0 and every `dispValid` bit is 0.
- R2: When `stall` and `flush` are both 0, each slot with its `inValid` bit set is written into a free entry at the clock edge, up to three per cycle. Within one cycle, slot 0 counts as the oldest and slot 2 as the youngest.
- R3: `stall` is 1 in any cycle where fewer than three entries are free. In such a cycle every allocation input is ignored.
- R4: A result broadcast (`bcValid`=1) whose `bcTag` equals the tag of a waiting source in any entry marks that source available and stores `bcData` into it. All entries are compared in the same cycle.
- R5: An incoming micro-operation whose source is not yet available, and whose tag equals a broadcast in its own allocation cycle, captures that broadcast value when it is written.
- R6: An entry can be dispatched once both of its sources are available. This happens in the cycle after the allocation edge or the capture edge that completed it, and never in the same cycle as the broadcast.
- R7: The 3-bit port field selects the port: 0 is integer port 0, 1 is integer port 1, 2 is load-address, 3 is store-address and 4 is floating-point. A micro-operation leaves only on its own port. Codes 5 to 7 never dispatch.
- R8: Each port dispatches at most one micro-operation per cycle, and it is the oldest ready one in allocation order. All five ports select in the same cycle.
- R9: A dispatched entry is freed at that clock edge, and its space counts as free from the next cycle onward.
- R10: A cycle with `flush`=1 empties every entry at its clock edge. During that cycle no port dispatches and allocation inputs are ignored.
- R11: A dispatched micro-operation presents its opcode, its reorder-buffer number and both of its captured source values on that port's output fields.
- R12: A source that is already available keeps its value when a later broadcast carries the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Recovery flush: empties the buffer |
| inValid | input | 3 | Per-slot allocation request |
| inOp | input | 3*OP_W | Per-slot opcode |
| inPort | input | 9 | Per-slot 3-bit port code |
| inRob | input | 3*ROB_W | Per-slot reorder-buffer number |
| inSrc0Valid | input | 3 | Per-slot: source 0 value already known |
| inSrc0Tag | input | 3*TAG_W | Per-slot source 0 producer tag |
| inSrc0Data | input | 3*DATA_W | Per-slot source 0 value |
| inSrc1Valid | input | 3 | Per-slot: source 1 value already known |
| inSrc1Tag | input | 3*TAG_W | Per-slot source 1 producer tag |
| inSrc1Data | input | 3*DATA_W | Per-slot source 1 value |
| bcValid | input | 1 | Result broadcast present |
| bcTag | input | TAG_W | Broadcast producer tag |
| bcData | input | DATA_W | Broadcast result value |
| stall | output | 1 | Fewer than three entries free |
| dispValid | output | 5 | Per-port dispatch strobe |
| dispOp | output | 5*OP_W | Per-port opcode |
| dispRob | output | 5*ROB_W | Per-port reorder-buffer number |
| dispSrc0 | output | 5*DATA_W | Per-port source 0 value |
| dispSrc1 | output | 5*DATA_W | Per-port source 1 value |

## Verification
`stall` and the dispatch outputs are combinational functions of the stored entries, plus `flush`. They therefore answer in the cycle in which the state holds. An allocation or a capture changes that state at the next rising edge, so its effect shows in the following cycle, and a flush suppresses dispatch in its own cycle. The bench drives each cycle's inputs just after the falling edge and compares all outputs one nanosecond later, before the rising edge. It compares them with a queue model that is ordered by age, and it advances that model exactly once per edge. Directed sequences cover the corner cases: same-cycle capture, a repeated tag on an already-available source, unused port codes, a full buffer and a flush that coincides with allocation. A long randomized run then mixes all of these.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int RS_DEPTH    = 8;
  localparam int RS_IDX_W    = $clog2(RS_DEPTH);
  localparam int ALLOC_SLOTS = 3;
  localparam int SLOT_W      = $clog2(ALLOC_SLOTS);
  localparam int NUM_PORTS   = 5;
  localparam int PORT_W      = 3;

  typedef enum logic [PORT_W-1:0] {
    PORT_INT0 = 3'd0,
    PORT_INT1 = 3'd1,
    PORT_LDA  = 3'd2,
    PORT_STA  = 3'd3,
    PORT_FP   = 3'd4
  } port_e;

  typedef struct packed {
    logic                                  flush;
    logic [ALLOC_SLOTS-1:0]                allocEn;
    logic [ALLOC_SLOTS-1:0][RS_IDX_W-1:0]  allocIdx;
    logic [NUM_PORTS-1:0]                  grantValid;
    logic [NUM_PORTS-1:0][RS_IDX_W-1:0]    grantIdx;
    logic [RS_DEPTH-1:0]                   releaseMask;
  } rs_strobe_t;
endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              flush,
  input  logic [ALLOC_SLOTS-1:0]            inValid,
  input  logic [RS_DEPTH-1:0]               entryValid,
  input  logic [RS_DEPTH-1:0]               entryReady,
  input  logic [RS_DEPTH-1:0][PORT_W-1:0]   entryPort,
  output logic                              stall,
  output rs_strobe_t                        strobe
);
  localparam int CNT_W = $clog2(RS_DEPTH + 1);

  logic [RS_DEPTH-1:0]                  freeMask;
  logic [CNT_W-1:0]                     freeCount;
  logic                                 accept;
  logic [RS_DEPTH-1:0]                  takenMask;
  logic [ALLOC_SLOTS-1:0]               pickFound;
  logic [ALLOC_SLOTS-1:0][RS_IDX_W-1:0] pickIdx;
  logic [ALLOC_SLOTS-1:0]               allocEn;
  logic [ALLOC_SLOTS-1:0][RS_DEPTH-1:0] slotMask;
  logic [RS_DEPTH-1:0]                  allocAll;
  logic [RS_DEPTH-1:0][RS_DEPTH-1:0]    newRow;
  logic [RS_DEPTH-1:0]                  newHit;
  // olderRow[e][j] = 1 : entry j was allocated before entry e
  logic [RS_DEPTH-1:0][RS_DEPTH-1:0]    olderRow;
  logic [NUM_PORTS-1:0][RS_DEPTH-1:0]   candVec;
  logic [NUM_PORTS-1:0][RS_DEPTH-1:0]   grantVec;
  logic [NUM_PORTS-1:0]                 grantValid;
  logic [NUM_PORTS-1:0][RS_IDX_W-1:0]   grantIdx;
  logic [RS_DEPTH-1:0]                  releaseMask;

  assign freeMask  = ~entryValid;
  assign freeCount = CNT_W'($countones(freeMask));
  assign stall     = freeCount < CNT_W'(ALLOC_SLOTS);
  assign accept    = !stall && !flush;

  // lowest-numbered free entries go to slots in order
  always_comb begin
    takenMask = '0;
    pickFound = '0;
    pickIdx   = '0;
    for (int s = 0; s < ALLOC_SLOTS; s++) begin
      for (int e = 0; e < RS_DEPTH; e++) begin
        if (!pickFound[s] && freeMask[e] && !takenMask[e]) begin
          pickFound[s] = 1'b1;
          pickIdx[s]   = RS_IDX_W'(e);
          takenMask[e] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    allocAll = '0;
    for (int s = 0; s < ALLOC_SLOTS; s++) begin
      allocEn[s]  = accept && inValid[s] && pickFound[s];
      slotMask[s] = allocEn[s] ? (RS_DEPTH'(1) << pickIdx[s]) : '0;
      allocAll    = allocAll | slotMask[s];
    end
  end

  // age row for each newly written entry: all live entries plus earlier slots
  always_comb begin
    logic [RS_DEPTH-1:0] lowerMask;
    newRow    = '0;
    newHit    = '0;
    lowerMask = '0;
    for (int s = 0; s < ALLOC_SLOTS; s++) begin
      if (allocEn[s]) begin
        newHit[pickIdx[s]] = 1'b1;
        newRow[pickIdx[s]] = entryValid | lowerMask;
      end
      lowerMask = lowerMask | slotMask[s];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      olderRow <= '0;
    end else begin
      for (int e = 0; e < RS_DEPTH; e++) begin
        if (newHit[e]) olderRow[e] <= newRow[e];
        else           olderRow[e] <= olderRow[e] & ~allocAll;
      end
    end
  end

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      always_comb begin
        grantIdx[p] = '0;
        for (int e = 0; e < RS_DEPTH; e++) begin
          candVec[p][e]  = entryReady[e] && (entryPort[e] == PORT_W'(p));
        end
        for (int e = 0; e < RS_DEPTH; e++) begin
          grantVec[p][e] = candVec[p][e] && !(|(candVec[p] & olderRow[e])) && !flush;
          if (grantVec[p][e]) grantIdx[p] = RS_IDX_W'(e);
        end
        grantValid[p] = |grantVec[p];
      end

      assert_one_grant_R8: assert property (@(posedge clk) disable iff (!rstN)
        $onehot0(grantVec[p]));
    end
  endgenerate

  always_comb begin
    releaseMask = '0;
    for (int p = 0; p < NUM_PORTS; p++) releaseMask = releaseMask | grantVec[p];
  end

  assign strobe.flush       = flush;
  assign strobe.allocEn     = allocEn;
  assign strobe.allocIdx    = pickIdx;
  assign strobe.grantValid  = grantValid;
  assign strobe.grantIdx    = grantIdx;
  assign strobe.releaseMask = releaseMask;

  // R3: a stalled cycle never grows the occupancy
  assert_stall_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> ($countones(entryValid) <= $past($countones(entryValid))));

  // R10: no dispatch while flushing
  assert_flush_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> (releaseMask == '0));
endmodule

// File: rtl/rs_datapath.sv
module rs_datapath
  import rs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 5,
  parameter int OP_W   = 6,
  parameter int ROB_W  = 5
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  rs_strobe_t                      strobe,
  input  logic [ALLOC_SLOTS*OP_W-1:0]     inOp,
  input  logic [ALLOC_SLOTS*PORT_W-1:0]   inPort,
  input  logic [ALLOC_SLOTS*ROB_W-1:0]    inRob,
  input  logic [ALLOC_SLOTS-1:0]          inSrc0Valid,
  input  logic [ALLOC_SLOTS*TAG_W-1:0]    inSrc0Tag,
  input  logic [ALLOC_SLOTS*DATA_W-1:0]   inSrc0Data,
  input  logic [ALLOC_SLOTS-1:0]          inSrc1Valid,
  input  logic [ALLOC_SLOTS*TAG_W-1:0]    inSrc1Tag,
  input  logic [ALLOC_SLOTS*DATA_W-1:0]   inSrc1Data,
  input  logic                            bcValid,
  input  logic [TAG_W-1:0]                bcTag,
  input  logic [DATA_W-1:0]               bcData,
  output logic [RS_DEPTH-1:0]             entryValid,
  output logic [RS_DEPTH-1:0]             entryReady,
  output logic [RS_DEPTH-1:0][PORT_W-1:0] entryPort,
  output logic [NUM_PORTS*OP_W-1:0]       dispOp,
  output logic [NUM_PORTS*ROB_W-1:0]      dispRob,
  output logic [NUM_PORTS*DATA_W-1:0]     dispSrc0,
  output logic [NUM_PORTS*DATA_W-1:0]     dispSrc1
);
  // incoming slots after same-cycle capture
  logic [ALLOC_SLOTS-1:0][OP_W-1:0]   slotOp;
  logic [ALLOC_SLOTS-1:0][PORT_W-1:0] slotPort;
  logic [ALLOC_SLOTS-1:0][ROB_W-1:0]  slotRob;
  logic [ALLOC_SLOTS-1:0]             slotV0, slotV1;
  logic [ALLOC_SLOTS-1:0][TAG_W-1:0]  slotT0, slotT1;
  logic [ALLOC_SLOTS-1:0][DATA_W-1:0] slotD0, slotD1;

  // entry storage
  logic [RS_DEPTH-1:0]             validQ, sv0Q, sv1Q;
  logic [RS_DEPTH-1:0][OP_W-1:0]   opQ;
  logic [RS_DEPTH-1:0][PORT_W-1:0] portQ;
  logic [RS_DEPTH-1:0][ROB_W-1:0]  robQ;
  logic [RS_DEPTH-1:0][TAG_W-1:0]  t0Q, t1Q;
  logic [RS_DEPTH-1:0][DATA_W-1:0] d0Q, d1Q;

  logic [RS_DEPTH-1:0]             wrHit, hit0, hit1;
  logic [RS_DEPTH-1:0][SLOT_W-1:0] wrSlot;

  always_comb begin
    for (int s = 0; s < ALLOC_SLOTS; s++) begin
      slotOp[s]   = inOp[s*OP_W +: OP_W];
      slotPort[s] = inPort[s*PORT_W +: PORT_W];
      slotRob[s]  = inRob[s*ROB_W +: ROB_W];
      slotT0[s]   = inSrc0Tag[s*TAG_W +: TAG_W];
      slotT1[s]   = inSrc1Tag[s*TAG_W +: TAG_W];
      slotV0[s]   = inSrc0Valid[s] || (bcValid && slotT0[s] == bcTag);
      slotV1[s]   = inSrc1Valid[s] || (bcValid && slotT1[s] == bcTag);
      slotD0[s]   = inSrc0Valid[s] ? inSrc0Data[s*DATA_W +: DATA_W] : bcData;
      slotD1[s]   = inSrc1Valid[s] ? inSrc1Data[s*DATA_W +: DATA_W] : bcData;
    end
  end

  // write routing and associative tag compare
  always_comb begin
    for (int e = 0; e < RS_DEPTH; e++) begin
      wrHit[e]  = 1'b0;
      wrSlot[e] = '0;
      for (int s = 0; s < ALLOC_SLOTS; s++) begin
        if (strobe.allocEn[s] && strobe.allocIdx[s] == RS_IDX_W'(e)) begin
          wrHit[e]  = 1'b1;
          wrSlot[e] = SLOT_W'(s);
        end
      end
      hit0[e] = validQ[e] && !sv0Q[e] && bcValid && (t0Q[e] == bcTag);
      hit1[e] = validQ[e] && !sv1Q[e] && bcValid && (t1Q[e] == bcTag);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      sv0Q   <= '0;
      sv1Q   <= '0;
    end else if (strobe.flush) begin
      validQ <= '0;
    end else begin
      for (int e = 0; e < RS_DEPTH; e++) begin
        if (wrHit[e]) begin
          validQ[e] <= 1'b1;
          sv0Q[e]   <= slotV0[wrSlot[e]];
          sv1Q[e]   <= slotV1[wrSlot[e]];
        end else begin
          if (strobe.releaseMask[e]) validQ[e] <= 1'b0;
          if (hit0[e]) sv0Q[e] <= 1'b1;
          if (hit1[e]) sv1Q[e] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < RS_DEPTH; e++) begin
      if (wrHit[e]) begin
        opQ[e]   <= slotOp[wrSlot[e]];
        portQ[e] <= slotPort[wrSlot[e]];
        robQ[e]  <= slotRob[wrSlot[e]];
        t0Q[e]   <= slotT0[wrSlot[e]];
        t1Q[e]   <= slotT1[wrSlot[e]];
        d0Q[e]   <= slotD0[wrSlot[e]];
        d1Q[e]   <= slotD1[wrSlot[e]];
      end else begin
        if (hit0[e]) d0Q[e] <= bcData;
        if (hit1[e]) d1Q[e] <= bcData;
      end
    end
  end

  assign entryValid = validQ;
  assign entryReady = validQ & sv0Q & sv1Q;
  assign entryPort  = portQ;

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_out
      assign dispOp[p*OP_W +: OP_W]       = opQ[strobe.grantIdx[p]];
      assign dispRob[p*ROB_W +: ROB_W]    = robQ[strobe.grantIdx[p]];
      assign dispSrc0[p*DATA_W +: DATA_W] = d0Q[strobe.grantIdx[p]];
      assign dispSrc1[p*DATA_W +: DATA_W] = d1Q[strobe.grantIdx[p]];

      assert_grant_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
        strobe.grantValid[p] |-> entryReady[strobe.grantIdx[p]]);
    end
    for (genvar e = 0; e < RS_DEPTH; e++) begin : g_ent
      assert_write_free_R2: assert property (@(posedge clk) disable iff (!rstN)
        wrHit[e] |-> !validQ[e]);
    end
  endgenerate

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> (validQ == '0));

  assert_release_frees_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|strobe.releaseMask) |=> ((validQ & $past(strobe.releaseMask)) == '0));
endmodule

// File: rtl/rs_station.sv
module rs_station
  import rs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 5,
  parameter int OP_W   = 6,
  parameter int ROB_W  = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          flush,
  input  logic [ALLOC_SLOTS-1:0]        inValid,
  input  logic [ALLOC_SLOTS*OP_W-1:0]   inOp,
  input  logic [ALLOC_SLOTS*PORT_W-1:0] inPort,
  input  logic [ALLOC_SLOTS*ROB_W-1:0]  inRob,
  input  logic [ALLOC_SLOTS-1:0]        inSrc0Valid,
  input  logic [ALLOC_SLOTS*TAG_W-1:0]  inSrc0Tag,
  input  logic [ALLOC_SLOTS*DATA_W-1:0] inSrc0Data,
  input  logic [ALLOC_SLOTS-1:0]        inSrc1Valid,
  input  logic [ALLOC_SLOTS*TAG_W-1:0]  inSrc1Tag,
  input  logic [ALLOC_SLOTS*DATA_W-1:0] inSrc1Data,
  input  logic                          bcValid,
  input  logic [TAG_W-1:0]              bcTag,
  input  logic [DATA_W-1:0]             bcData,
  output logic                          stall,
  output logic [NUM_PORTS-1:0]          dispValid,
  output logic [NUM_PORTS*OP_W-1:0]     dispOp,
  output logic [NUM_PORTS*ROB_W-1:0]    dispRob,
  output logic [NUM_PORTS*DATA_W-1:0]   dispSrc0,
  output logic [NUM_PORTS*DATA_W-1:0]   dispSrc1
);
  rs_strobe_t                      strobe;
  logic [RS_DEPTH-1:0]             entryValid;
  logic [RS_DEPTH-1:0]             entryReady;
  logic [RS_DEPTH-1:0][PORT_W-1:0] entryPort;

  rs_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .flush      (flush),
    .inValid    (inValid),
    .entryValid (entryValid),
    .entryReady (entryReady),
    .entryPort  (entryPort),
    .stall      (stall),
    .strobe     (strobe)
  );

  rs_datapath #(
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W),
    .OP_W   (OP_W),
    .ROB_W  (ROB_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .inOp        (inOp),
    .inPort      (inPort),
    .inRob       (inRob),
    .inSrc0Valid (inSrc0Valid),
    .inSrc0Tag   (inSrc0Tag),
    .inSrc0Data  (inSrc0Data),
    .inSrc1Valid (inSrc1Valid),
    .inSrc1Tag   (inSrc1Tag),
    .inSrc1Data  (inSrc1Data),
    .bcValid     (bcValid),
    .bcTag       (bcTag),
    .bcData      (bcData),
    .entryValid  (entryValid),
    .entryReady  (entryReady),
    .entryPort   (entryPort),
    .dispOp      (dispOp),
    .dispRob     (dispRob),
    .dispSrc0    (dispSrc0),
    .dispSrc1    (dispSrc1)
  );

  assign dispValid = strobe.grantValid;
endmodule

// File: tb/rs_station_bench.sv
`timescale 1ns/1ps
module rs_station_bench;
  import rs_pkg::*;
  localparam int DW = 16;
  localparam int TW = 5;
  localparam int OW = 6;
  localparam int RW = 5;
  localparam int S  = ALLOC_SLOTS;
  localparam int P  = NUM_PORTS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0;
  logic [S-1:0]    inValid = '0;
  logic [S*OW-1:0] inOp = '0;
  logic [S*3-1:0]  inPort = '0;
  logic [S*RW-1:0] inRob = '0;
  logic [S-1:0]    inSrc0Valid = '0, inSrc1Valid = '0;
  logic [S*TW-1:0] inSrc0Tag = '0, inSrc1Tag = '0;
  logic [S*DW-1:0] inSrc0Data = '0, inSrc1Data = '0;
  logic            bcValid = 1'b0;
  logic [TW-1:0]   bcTag = '0;
  logic [DW-1:0]   bcData = '0;
  logic            stall;
  logic [P-1:0]    dispValid;
  logic [P*OW-1:0] dispOp;
  logic [P*RW-1:0] dispRob;
  logic [P*DW-1:0] dispSrc0, dispSrc1;

  always #2.5 clk = ~clk;

  rs_station #(.DATA_W(DW), .TAG_W(TW), .OP_W(OW), .ROB_W(RW)) u_rs_station (
    .clk(clk), .rstN(rstN), .flush(flush), .inValid(inValid), .inOp(inOp),
    .inPort(inPort), .inRob(inRob), .inSrc0Valid(inSrc0Valid), .inSrc0Tag(inSrc0Tag),
    .inSrc0Data(inSrc0Data), .inSrc1Valid(inSrc1Valid), .inSrc1Tag(inSrc1Tag),
    .inSrc1Data(inSrc1Data), .bcValid(bcValid), .bcTag(bcTag), .bcData(bcData),
    .stall(stall), .dispValid(dispValid), .dispOp(dispOp), .dispRob(dispRob),
    .dispSrc0(dispSrc0), .dispSrc1(dispSrc1)
  );

  typedef struct {
    logic [OW-1:0] op;
    logic [2:0]    port;
    logic [RW-1:0] rob;
    logic          v0, v1;
    logic [TW-1:0] t0, t1;
    logic [DW-1:0] d0, d1;
  } rec_t;

  rec_t  model[$];          // live micro-ops, oldest first
  int    vectors = 0;
  int    miscompares = 0;
  bit    finished = 1'b0;
  string label = "R1";

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic loadSlot(int s, int op, int port, int rob,
                          bit v0, int t0, int d0, bit v1, int t1, int d1);
    inValid[s] = 1'b1;
    inOp[s*OW +: OW]         = OW'(op);
    inPort[s*3 +: 3]         = 3'(port);
    inRob[s*RW +: RW]        = RW'(rob);
    inSrc0Valid[s]           = v0;
    inSrc0Tag[s*TW +: TW]    = TW'(t0);
    inSrc0Data[s*DW +: DW]   = DW'(d0);
    inSrc1Valid[s]           = v1;
    inSrc1Tag[s*TW +: TW]    = TW'(t1);
    inSrc1Data[s*DW +: DW]   = DW'(d1);
  endtask

  task automatic broadcast(int tag, int data);
    bcValid = 1'b1;
    bcTag   = TW'(tag);
    bcData  = DW'(data);
  endtask

  task automatic idleInputs();
    inValid = '0;
    flush   = 1'b0;
    bcValid = 1'b0;
  endtask

  // compare this cycle, advance the model across the next edge
  task automatic tick();
    int   pick[P];
    bit   expStall;
    rec_t nq[$];
    rec_t r;
    bit   gone;
    #1;
    expStall = (RS_DEPTH - model.size()) < S;
    check("R3", "stall", 64'(stall), 64'(expStall));
    for (int p = 0; p < P; p++) begin
      pick[p] = -1;
      if (!flush) begin
        for (int i = 0; i < model.size(); i++) begin
          if (pick[p] < 0 && int'(model[i].port) == p && model[i].v0 && model[i].v1)
            pick[p] = i;
        end
      end
      check(label, $sformatf("dispValid[%0d]", p), 64'(dispValid[p]), 64'(pick[p] >= 0));
      if (pick[p] >= 0) begin
        check("R11", "dispOp",   64'(dispOp[p*OW +: OW]),     64'(model[pick[p]].op));
        check("R11", "dispRob",  64'(dispRob[p*RW +: RW]),    64'(model[pick[p]].rob));
        check(label, "dispSrc0", 64'(dispSrc0[p*DW +: DW]),   64'(model[pick[p]].d0));
        check(label, "dispSrc1", 64'(dispSrc1[p*DW +: DW]),   64'(model[pick[p]].d1));
      end
    end
    if (flush) begin
      model.delete();
    end else begin
      for (int i = 0; i < model.size(); i++) begin
        gone = 1'b0;
        for (int p = 0; p < P; p++) if (pick[p] == i) gone = 1'b1;
        if (!gone) begin
          r = model[i];
          if (!r.v0 && bcValid && r.t0 == bcTag) begin r.v0 = 1'b1; r.d0 = bcData; end
          if (!r.v1 && bcValid && r.t1 == bcTag) begin r.v1 = 1'b1; r.d1 = bcData; end
          nq.push_back(r);
        end
      end
      if (!expStall) begin
        for (int s = 0; s < S; s++) begin
          if (inValid[s]) begin
            r.op   = inOp[s*OW +: OW];
            r.port = inPort[s*3 +: 3];
            r.rob  = inRob[s*RW +: RW];
            r.t0   = inSrc0Tag[s*TW +: TW];
            r.t1   = inSrc1Tag[s*TW +: TW];
            r.v0   = inSrc0Valid[s] || (bcValid && r.t0 == bcTag);
            r.v1   = inSrc1Valid[s] || (bcValid && r.t1 == bcTag);
            r.d0   = inSrc0Valid[s] ? inSrc0Data[s*DW +: DW] : bcData;
            r.d1   = inSrc1Valid[s] ? inSrc1Data[s*DW +: DW] : bcData;
            nq.push_back(r);
          end
        end
      end
      model = nq;
    end
    @(negedge clk);
    idleInputs();
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired in phase %s", label);
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    check("R1", "stall in reset", 64'(stall), 64'(0));
    check("R1", "dispValid in reset", 64'(dispValid), 64'(0));
    @(negedge clk);
    rstN = 1'b1;
    tick();

    // R2: three ready ops in one cycle, ports 0/1/2
    label = "R2";
    loadSlot(0, 1, 0, 1, 1, 0, 16'h1111, 1, 0, 16'h2222);
    loadSlot(1, 2, 1, 2, 1, 0, 16'h3333, 1, 0, 16'h4444);
    loadSlot(2, 3, 2, 3, 1, 0, 16'h5555, 1, 0, 16'h6666);
    tick();
    tick();
    tick();

    // R8: same-port ops leave one per cycle, oldest first
    label = "R8";
    loadSlot(0, 10, 4, 10, 1, 0, 16'hA0, 1, 0, 16'hA1);
    loadSlot(1, 11, 4, 11, 1, 0, 16'hB0, 1, 0, 16'hB1);
    loadSlot(2, 12, 4, 12, 1, 0, 16'hC0, 1, 0, 16'hC1);
    tick();
    loadSlot(0, 13, 4, 13, 1, 0, 16'hD0, 1, 0, 16'hD1);
    tick();
    repeat (4) tick();

    // R4: later broadcast wakes a waiting source
    label = "R4";
    loadSlot(0, 20, 1, 20, 0, 9, 0, 1, 0, 16'h0F0F);
    tick();
    tick();
    broadcast(9, 16'h1234);
    tick();
    tick();
    tick();

    // R5: capture in the allocation cycle
    label = "R5";
    loadSlot(0, 21, 0, 21, 1, 0, 16'h7777, 0, 12, 0);
    broadcast(12, 16'hBEEF);
    tick();
    tick();

    // R12: an available source ignores a repeat of its tag
    label = "R12";
    loadSlot(0, 22, 3, 22, 1, 7, 16'h0055, 0, 7, 0);
    tick();
    broadcast(7, 16'h0099);
    tick();
    tick();

    // R7: unused port code never dispatches
    label = "R7";
    loadSlot(0, 23, 6, 23, 1, 0, 1, 1, 0, 2);
    repeat (4) tick();

    // R3: fill until stalled, then try to allocate
    label = "R3";
    for (int k = 0; k < 3; k++) begin
      loadSlot(0, 30 + k, 0, 1, 0, 20, 0, 1, 0, k);
      loadSlot(1, 40 + k, 1, 2, 0, 20, 0, 1, 0, k);
      loadSlot(2, 50 + k, 2, 3, 1, 0, k, 0, 20, 0);
      tick();
    end
    tick();

    // R9: release entries by wakeup and dispatch
    label = "R9";
    broadcast(20, 16'hCAFE);
    tick();
    repeat (4) tick();
    loadSlot(0, 60, 3, 4, 1, 0, 5, 1, 0, 6);
    loadSlot(1, 61, 3, 5, 1, 0, 7, 1, 0, 8);
    tick();
    tick();

    // R10: flush with concurrent allocation
    label = "R10";
    loadSlot(0, 62, 0, 6, 1, 0, 9, 1, 0, 9);
    loadSlot(1, 63, 1, 7, 0, 3, 0, 1, 0, 9);
    tick();
    flush = 1'b1;
    loadSlot(0, 1, 2, 8, 1, 0, 1, 1, 0, 1);
    tick();
    tick();
    tick();

    // R6: randomized traffic
    label = "R6";
    for (int c = 0; c < 4000; c++) begin
      flush = ($urandom_range(0, 59) == 0);
      for (int s = 0; s < S; s++) begin
        if ($urandom_range(0, 2) != 0)
          loadSlot(s, $urandom_range(0, 63), $urandom_range(0, 5), $urandom_range(0, 31),
                   1'($urandom_range(0, 1)), $urandom_range(0, 7), $urandom_range(0, 65535),
                   1'($urandom_range(0, 1)), $urandom_range(0, 7), $urandom_range(0, 65535));
      end
      if ($urandom_range(0, 1) != 0)
        broadcast($urandom_range(0, 7), $urandom_range(0, 65535));
      tick();
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule